// File: doc/BRIEF.md
# Byte and Pair Register File

This block is the working-register store of a small 8-bit datapath. It keeps six general byte registers, an accumulator, a 16-bit stack pointer and a carry flag. The control logic reads and writes single bytes through a 3-bit register code. It also issues pair operations that treat two byte registers, or the stack pointer, as one 16-bit word. The pair operations are immediate load, increment, decrement, adding a pair into HL, swapping HL with DE, and copying HL into the stack pointer. Each pair operation completes in a single clock cycle.

The H:L word is always visible on its own output. Surrounding logic uses it as the address of a memory operand and as the target of a register-indirect jump. Memory access and instruction decoding sit outside the block. It receives decoded operation codes and operands and has no handshake.

Top module: `pair_regfile`

## Requirements
- R1: A synchronous active-high reset clears every byte register, the stack pointer and the carry flag to zero.
- R2: Byte codes are B=0, C=1, D=2, E=3, H=4, L=5, A=7. A byte write with `wr8_en` high updates the selected register at the next rising edge. The read ports `rd0_data` and `rd1_data` show the selected register combinationally.
- R3: Byte code 6 stands for a memory operand. A write to it changes no register, and a read of it returns zero.
- R4: Pair codes are 00=BC, 01=DE, 10=HL, 11=SP. `pair_data` shows the pair chosen by `pr_sel` combinationally, with the high register (B, D or H) in bits 15:8.
- R5: Pair op 1 (load) writes `pr_imm[15:8]` to the high register of the selected pair and `pr_imm[7:0]` to the low register, or writes all 16 bits to SP.
- R6: Pair op 2 (increment) and op 3 (decrement) change the selected pair by one, modulo 65536 (FFFF+1=0000, 0000-1=FFFF), and leave the carry flag unchanged.
- R7: Pair op 4 (double add) sets HL to HL plus the selected pair, with HL allowed as the operand. The carry flag takes the carry out of bit 15.
- R8: Pair op 5 swaps the full HL and DE contents in one cycle, whatever the value of `pr_sel`.
- R9: Pair op 6 loads SP from HL, whatever the value of `pr_sel`.
- R10: `hl_addr` always equals the current H:L value, so it follows every change to H or L.
- R11: While a pair op from 1 to 6 is active, a byte write in the same cycle is dropped. Op 0 and op 7 leave byte writes in effect.
- R12: The carry flag changes only on a double add.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr8_en | input | 1 | Byte write strobe |
| wr8_sel | input | 3 | Byte register code for the write |
| wr8_data | input | 8 | Byte write value |
| rd0_sel | input | 3 | Byte code for read port 0 |
| rd0_data | output | 8 | Read port 0 value |
| rd1_sel | input | 3 | Byte code for read port 1 |
| rd1_data | output | 8 | Read port 1 value |
| pr_op | input | 3 | Pair op: 0 none, 1 load, 2 inc, 3 dec, 4 double add, 5 swap HL/DE, 6 HL to SP, 7 none |
| pr_sel | input | 2 | Pair code |
| pr_imm | input | 16 | Immediate for pair load |
| pair_data | output | 16 | Value of the pair selected by `pr_sel` |
| hl_addr | output | 16 | Current H:L, used as memory address and jump target |
| sp_out | output | 16 | Stack pointer |
| acc_out | output | 8 | Accumulator |
| cy_flag | output | 1 | Carry flag |

## Verification
The bench drives the wrap points of the pair counters: 00FF to 0100 across the byte boundary, FFFF to 0000 on SP, and 0000 to FFFF on BC. A design that counts in bytes, or that never carries into the high register, would show a wrong high byte at these points. The double add is tried with HL as its own operand and with operands that do and do not carry out of bit 15. This catches a stale carry and a wrong operand source. Byte writes are issued in the same cycle as pair operations, and a write is aimed at code 6. A leaky write here would show up on the accumulator, on `hl_addr`, or on the pair outputs.

// File: rtl/rfp_pkg.sv
`timescale 1ns/1ps
package rfp_pkg;
   typedef enum logic [2:0] {
      PO_NOP  = 3'd0,
      PO_LOAD = 3'd1,
      PO_INC  = 3'd2,
      PO_DEC  = 3'd3,
      PO_DAD  = 3'd4,
      PO_XCHG = 3'd5,
      PO_SPHL = 3'd6,
      PO_RSVD = 3'd7
   } pair_op_e;

   localparam logic [2:0] REG_H   = 3'd4;
   localparam logic [2:0] REG_L   = 3'd5;
   localparam logic [2:0] REG_MEM = 3'd6;
   localparam logic [2:0] REG_A   = 3'd7;
   localparam logic [2:0] REG_D   = 3'd2;
   localparam logic [2:0] REG_E   = 3'd3;
   localparam logic [1:0] PAIR_SP = 2'd3;

   function automatic logic is_pair_op(pair_op_e op);
      return (op != PO_NOP) && (op != PO_RSVD);
   endfunction
endpackage

// File: rtl/rf_byte_mux.sv
`timescale 1ns/1ps
module rf_byte_mux #(
   parameter int BYTE_W = 8,
   parameter int NREG   = 8
) (
   input  logic [NREG*BYTE_W-1:0] regs_flat,
   input  logic [2:0]             sel,
   output logic [BYTE_W-1:0]      data
);
   import rfp_pkg::*;

   always_comb begin
      if (sel == REG_MEM) data = '0;
      else                data = regs_flat[sel*BYTE_W +: BYTE_W];
   end
endmodule

// File: rtl/rf_pair_alu.sv
`timescale 1ns/1ps
module rf_pair_alu #(
   parameter int BYTE_W    = 8,
   parameter bit SPLIT_ADD = 1'b1
) (
   input  rfp_pkg::pair_op_e   op,
   input  logic [2*BYTE_W-1:0] opnd,
   input  logic [2*BYTE_W-1:0] hl,
   output logic [2*BYTE_W-1:0] res,
   output logic                cout
);
   import rfp_pkg::*;
   localparam int PW = 2*BYTE_W;

   logic [PW-1:0] sum;
   logic          sum_c;

   generate
      if (SPLIT_ADD) begin : g_split
         logic [BYTE_W:0] lo_s;
         logic [BYTE_W:0] hi_s;
         always_comb begin
            lo_s = {1'b0, hl[BYTE_W-1:0]} + {1'b0, opnd[BYTE_W-1:0]};
            hi_s = {1'b0, hl[PW-1:BYTE_W]} + {1'b0, opnd[PW-1:BYTE_W]}
                   + {{BYTE_W{1'b0}}, lo_s[BYTE_W]};
         end
         assign sum   = {hi_s[BYTE_W-1:0], lo_s[BYTE_W-1:0]};
         assign sum_c = hi_s[BYTE_W];
      end else begin : g_flat
         logic [PW:0] full_s;
         assign full_s = {1'b0, hl} + {1'b0, opnd};
         assign sum    = full_s[PW-1:0];
         assign sum_c  = full_s[PW];
      end
   endgenerate

   always_comb begin
      res  = opnd;
      cout = 1'b0;
      unique case (op)
         PO_INC:  res = opnd + PW'(1);
         PO_DEC:  res = opnd - PW'(1);
         PO_DAD:  begin res = sum; cout = sum_c; end
         default: res = opnd;
      endcase
   end
endmodule

// File: rtl/rf_store.sv
`timescale 1ns/1ps
module rf_store #(
   parameter int BYTE_W = 8,
   parameter int NREG   = 8
) (
   input  logic                   clk,
   input  logic                   rst,
   input  rfp_pkg::pair_op_e      op,
   input  logic [1:0]             pr_sel,
   input  logic [2*BYTE_W-1:0]    pr_imm,
   input  logic [2*BYTE_W-1:0]    alu_res,
   input  logic                   alu_cout,
   input  logic                   wr8_en,
   input  logic [2:0]             wr8_sel,
   input  logic [BYTE_W-1:0]      wr8_data,
   output logic [NREG*BYTE_W-1:0] regs_flat,
   output logic [2*BYTE_W-1:0]    sp_q,
   output logic                   cy_q
);
   import rfp_pkg::*;
   localparam int PW = 2*BYTE_W;

   logic [NREG-1:0][BYTE_W-1:0] regs_q, regs_d;
   logic [PW-1:0]               sp_d;
   logic                        cy_d;
   logic [PW-1:0]               pair_val;

   always_comb begin
      regs_d   = regs_q;
      sp_d     = sp_q;
      cy_d     = cy_q;
      pair_val = (op == PO_LOAD) ? pr_imm : alu_res;
      unique case (op)
         PO_LOAD, PO_INC, PO_DEC: begin
            if (pr_sel == PAIR_SP) sp_d = pair_val;
            else begin
               regs_d[{pr_sel, 1'b0}] = pair_val[PW-1:BYTE_W];
               regs_d[{pr_sel, 1'b1}] = pair_val[BYTE_W-1:0];
            end
         end
         PO_DAD: begin
            regs_d[REG_H] = alu_res[PW-1:BYTE_W];
            regs_d[REG_L] = alu_res[BYTE_W-1:0];
            cy_d          = alu_cout;
         end
         PO_XCHG: begin
            regs_d[REG_H] = regs_q[REG_D];
            regs_d[REG_L] = regs_q[REG_E];
            regs_d[REG_D] = regs_q[REG_H];
            regs_d[REG_E] = regs_q[REG_L];
         end
         PO_SPHL: sp_d = {regs_q[REG_H], regs_q[REG_L]};
         default: begin
            if (wr8_en && wr8_sel != REG_MEM) regs_d[wr8_sel] = wr8_data;
         end
      endcase
      regs_d[REG_MEM] = '0;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         regs_q <= '0;
         sp_q   <= '0;
         cy_q   <= 1'b0;
      end else begin
         regs_q <= regs_d;
         sp_q   <= sp_d;
         cy_q   <= cy_d;
      end
   end

   assign regs_flat = regs_q;
endmodule

// File: rtl/pair_regfile.sv
`timescale 1ns/1ps
module pair_regfile #(
   parameter int BYTE_W    = 8,
   parameter bit SPLIT_ADD = 1'b1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                wr8_en,
   input  logic [2:0]          wr8_sel,
   input  logic [BYTE_W-1:0]   wr8_data,
   input  logic [2:0]          rd0_sel,
   output logic [BYTE_W-1:0]   rd0_data,
   input  logic [2:0]          rd1_sel,
   output logic [BYTE_W-1:0]   rd1_data,
   input  logic [2:0]          pr_op,
   input  logic [1:0]          pr_sel,
   input  logic [2*BYTE_W-1:0] pr_imm,
   output logic [2*BYTE_W-1:0] pair_data,
   output logic [2*BYTE_W-1:0] hl_addr,
   output logic [2*BYTE_W-1:0] sp_out,
   output logic [BYTE_W-1:0]   acc_out,
   output logic                cy_flag
);
   import rfp_pkg::*;
   localparam int NREG  = 8;
   localparam int PW    = 2*BYTE_W;
   localparam int NPORT = 2;

   generate
      if (BYTE_W < 2) begin : g_bad_width
         $error("pair_regfile: BYTE_W must be at least 2");
      end
   endgenerate

   pair_op_e                op;
   logic [NREG*BYTE_W-1:0]  regs_flat;
   logic [PW-1:0]           alu_res;
   logic                    alu_cout;
   logic [PW-1:0]           de_val;
   logic [NPORT*3-1:0]      rd_sel_bus;
   logic [NPORT*BYTE_W-1:0] rd_data_bus;

   assign op = pair_op_e'(pr_op);

   rf_store #(.BYTE_W(BYTE_W), .NREG(NREG)) u_store (
      .clk(clk), .rst(rst), .op(op), .pr_sel(pr_sel), .pr_imm(pr_imm),
      .alu_res(alu_res), .alu_cout(alu_cout),
      .wr8_en(wr8_en), .wr8_sel(wr8_sel), .wr8_data(wr8_data),
      .regs_flat(regs_flat), .sp_q(sp_out), .cy_q(cy_flag)
   );

   always_comb begin
      if (pr_sel == PAIR_SP) pair_data = sp_out;
      else pair_data = {regs_flat[{pr_sel, 1'b0}*BYTE_W +: BYTE_W],
                        regs_flat[{pr_sel, 1'b1}*BYTE_W +: BYTE_W]};
   end

   assign hl_addr = {regs_flat[REG_H*BYTE_W +: BYTE_W], regs_flat[REG_L*BYTE_W +: BYTE_W]};
   assign de_val  = {regs_flat[REG_D*BYTE_W +: BYTE_W], regs_flat[REG_E*BYTE_W +: BYTE_W]};
   assign acc_out = regs_flat[REG_A*BYTE_W +: BYTE_W];

   rf_pair_alu #(.BYTE_W(BYTE_W), .SPLIT_ADD(SPLIT_ADD)) u_alu (
      .op(op), .opnd(pair_data), .hl(hl_addr), .res(alu_res), .cout(alu_cout)
   );

   assign rd_sel_bus = {rd1_sel, rd0_sel};

   generate
      for (genvar p = 0; p < NPORT; p++) begin : g_rd
         rf_byte_mux #(.BYTE_W(BYTE_W), .NREG(NREG)) u_mux (
            .regs_flat(regs_flat),
            .sel(rd_sel_bus[p*3 +: 3]),
            .data(rd_data_bus[p*BYTE_W +: BYTE_W])
         );
      end
   endgenerate

   assign rd0_data = rd_data_bus[0 +: BYTE_W];
   assign rd1_data = rd_data_bus[BYTE_W +: BYTE_W];
endmodule

// File: rtl/rf_pair_chk.sv
`timescale 1ns/1ps
module rf_pair_chk #(
   parameter int BYTE_W = 8
) (
   input logic                clk,
   input logic                rst,
   input logic [2:0]          pr_op,
   input logic [1:0]          pr_sel,
   input logic                wr8_en,
   input logic [2:0]          wr8_sel,
   input logic [2*BYTE_W-1:0] pair_data,
   input logic [2*BYTE_W-1:0] hl_addr,
   input logic [2*BYTE_W-1:0] de_val,
   input logic [2*BYTE_W-1:0] sp_out,
   input logic [BYTE_W-1:0]   acc_out,
   input logic                cy_flag
);
   localparam int PW = 2*BYTE_W;

   a_r6_inc_hl: assert property (@(posedge clk) disable iff (rst)
      (pr_op == 3'd2 && pr_sel == 2'd2) |=> hl_addr == $past(hl_addr) + PW'(1));

   a_r6_dec_sp: assert property (@(posedge clk) disable iff (rst)
      (pr_op == 3'd3 && pr_sel == 2'd3) |=> sp_out == $past(sp_out) - PW'(1));

   a_r7_dad_sum: assert property (@(posedge clk) disable iff (rst)
      (pr_op == 3'd4) |=> {cy_flag, hl_addr} ==
         ({1'b0, $past(hl_addr)} + {1'b0, $past(pair_data)}));

   a_r8_swap: assert property (@(posedge clk) disable iff (rst)
      (pr_op == 3'd5) |=> (hl_addr == $past(de_val)) && (de_val == $past(hl_addr)));

   a_r9_hl_to_sp: assert property (@(posedge clk) disable iff (rst)
      (pr_op == 3'd6) |=> sp_out == $past(hl_addr));

   a_r11_write_dropped: assert property (@(posedge clk) disable iff (rst)
      (wr8_en && wr8_sel == 3'd7 && pr_op != 3'd0 && pr_op != 3'd7) |=> $stable(acc_out));

   a_r12_carry_hold: assert property (@(posedge clk) disable iff (rst)
      (pr_op != 3'd4) |=> $stable(cy_flag));
endmodule

bind pair_regfile rf_pair_chk #(.BYTE_W(BYTE_W)) u_chk (
   .clk(clk), .rst(rst), .pr_op(pr_op), .pr_sel(pr_sel),
   .wr8_en(wr8_en), .wr8_sel(wr8_sel), .pair_data(pair_data),
   .hl_addr(hl_addr), .de_val(de_val), .sp_out(sp_out),
   .acc_out(acc_out), .cy_flag(cy_flag)
);

// File: tb/tb_pair_regfile.sv
`timescale 1ns/1ps
module tb_pair_regfile;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr8_en = 1'b0;
   logic [2:0]  wr8_sel = '0;
   logic [7:0]  wr8_data = '0;
   logic [2:0]  rd0_sel = '0, rd1_sel = '0;
   logic [7:0]  rd0_data, rd1_data;
   logic [2:0]  pr_op = '0;
   logic [1:0]  pr_sel = '0;
   logic [15:0] pr_imm = '0;
   logic [15:0] pair_data, hl_addr, sp_out;
   logic [7:0]  acc_out;
   logic        cy_flag;

   int ncmp = 0;
   int nbad = 0;

   always #2 clk = ~clk;

   pair_regfile dut (
      .clk(clk), .rst(rst), .wr8_en(wr8_en), .wr8_sel(wr8_sel), .wr8_data(wr8_data),
      .rd0_sel(rd0_sel), .rd0_data(rd0_data), .rd1_sel(rd1_sel), .rd1_data(rd1_data),
      .pr_op(pr_op), .pr_sel(pr_sel), .pr_imm(pr_imm), .pair_data(pair_data),
      .hl_addr(hl_addr), .sp_out(sp_out), .acc_out(acc_out), .cy_flag(cy_flag)
   );

   // reference state
   logic [7:0]  m [8];
   logic [15:0] msp;
   logic        mcy;

   typedef struct {
      string       tag;
      logic [15:0] hl, sp, pv;
      logic [7:0]  acc;
      logic        cy;
   } exp_t;
   exp_t sbq[$];

   function automatic logic [15:0] mget(logic [1:0] s);
      if (s == 2'd3) return msp;
      return {m[2*s], m[2*s+1]};
   endfunction

   task automatic mset(logic [1:0] s, logic [15:0] v);
      if (s == 2'd3) msp = v;
      else begin m[2*s] = v[15:8]; m[2*s+1] = v[7:0]; end
   endtask

   task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
      ncmp++;
      if (got !== exp) begin
         nbad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic step(logic [2:0] op, logic [1:0] s, logic [15:0] imm,
                       logic we, logic [2:0] ws, logic [7:0] wd, string tag);
      exp_t e;
      logic [16:0] sum;
      logic [7:0]  t0, t1;
      @(negedge clk);
      pr_op = op; pr_sel = s; pr_imm = imm;
      wr8_en = we; wr8_sel = ws; wr8_data = wd;
      case (op)
         3'd1: mset(s, imm);
         3'd2: mset(s, mget(s) + 16'd1);
         3'd3: mset(s, mget(s) - 16'd1);
         3'd4: begin
            sum = {1'b0, mget(2'd2)} + {1'b0, mget(s)};
            mset(2'd2, sum[15:0]); mcy = sum[16];
         end
         3'd5: begin
            t0 = m[4]; t1 = m[5];
            m[4] = m[2]; m[5] = m[3]; m[2] = t0; m[3] = t1;
         end
         3'd6: msp = mget(2'd2);
         default: if (we && ws != 3'd6) m[ws] = wd;
      endcase
      e.tag = tag; e.hl = mget(2'd2); e.sp = msp; e.pv = mget(s);
      e.acc = m[7]; e.cy = mcy;
      sbq.push_back(e);
      @(negedge clk);
      pr_op = 3'd0; wr8_en = 1'b0;
   endtask

   task automatic rdchk(logic [2:0] s, logic [7:0] exp, string tag);
      rd0_sel = s; rd1_sel = s;
      #1;
      chk({tag, " rd0"}, {24'd0, rd0_data}, {24'd0, exp});
      chk({tag, " rd1"}, {24'd0, rd1_data}, {24'd0, exp});
   endtask

   task automatic pchk(logic [1:0] s, string tag);
      pr_sel = s;
      #1;
      chk(tag, {16'd0, pair_data}, {16'd0, mget(s)});
   endtask

   // scoreboard monitor
   always @(posedge clk) begin
      #1;
      if (sbq.size() > 0) begin
         exp_t e;
         e = sbq.pop_front();
         chk({e.tag, " R10 hl_addr"}, {16'd0, hl_addr}, {16'd0, e.hl});
         chk({e.tag, " sp"},  {16'd0, sp_out},    {16'd0, e.sp});
         chk({e.tag, " pair"}, {16'd0, pair_data}, {16'd0, e.pv});
         chk({e.tag, " acc"}, {24'd0, acc_out},   {24'd0, e.acc});
         chk({e.tag, " R12 carry"}, {31'd0, cy_flag}, {31'd0, e.cy});
      end
   end

   task automatic clear_model();
      for (int i = 0; i < 8; i++) m[i] = 8'h00;
      msp = 16'h0000; mcy = 1'b0;
   endtask

   initial begin : watchdog
      #(4 * 20000);
      nbad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
      $finish;
   end

   initial begin : main
      clear_model();
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R2: byte writes then reads
      step(3'd0, 2'd0, 16'h0, 1'b1, 3'd0, 8'h12, "R2 wB");
      step(3'd0, 2'd0, 16'h0, 1'b1, 3'd1, 8'h34, "R2 wC");
      step(3'd0, 2'd1, 16'h0, 1'b1, 3'd2, 8'h56, "R2 wD");
      step(3'd0, 2'd1, 16'h0, 1'b1, 3'd3, 8'h78, "R2 wE");
      step(3'd0, 2'd2, 16'h0, 1'b1, 3'd4, 8'h9A, "R2 wH");
      step(3'd0, 2'd2, 16'h0, 1'b1, 3'd5, 8'hBC, "R2 wL");
      step(3'd7, 2'd2, 16'h0, 1'b1, 3'd7, 8'h5A, "R11 op7 keeps write wA");
      for (int i = 0; i < 8; i++) if (i != 6) rdchk(3'(i), m[i], "R2 read");
      // R3: memory code ignored on write, reads zero
      step(3'd0, 2'd2, 16'h0, 1'b1, 3'd6, 8'hFF, "R3 write code6");
      rdchk(3'd6, 8'h00, "R3 read code6");
      for (int i = 0; i < 8; i++) if (i != 6) rdchk(3'(i), m[i], "R3 others intact");
      // R4: pair view
      for (int i = 0; i < 4; i++) pchk(2'(i), "R4 pair view");
      // R1: reset clears everything
      @(negedge clk); rst = 1'b1;
      @(negedge clk); @(negedge clk);
      clear_model();
      chk("R1 hl", {16'd0, hl_addr}, 32'd0);
      chk("R1 sp", {16'd0, sp_out}, 32'd0);
      chk("R1 acc", {24'd0, acc_out}, 32'd0);
      chk("R1 cy", {31'd0, cy_flag}, 32'd0);
      for (int i = 0; i < 8; i++) rdchk(3'(i), 8'h00, "R1 byte");
      rst = 1'b0;
      // R5: immediate loads
      step(3'd1, 2'd0, 16'h00FF, 1'b0, 3'd0, 8'h0, "R5 load BC");
      rdchk(3'd0, 8'h00, "R5 B high byte");
      rdchk(3'd1, 8'hFF, "R5 C low byte");
      step(3'd1, 2'd1, 16'h5678, 1'b0, 3'd0, 8'h0, "R5 load DE");
      step(3'd1, 2'd2, 16'h9ABC, 1'b0, 3'd0, 8'h0, "R5 load HL");
      step(3'd1, 2'd3, 16'hFFFF, 1'b0, 3'd0, 8'h0, "R5 load SP");
      // R6: increment / decrement with wrap
      step(3'd2, 2'd0, 16'h0, 1'b0, 3'd0, 8'h0, "R6 inc BC 00FF");
      rdchk(3'd0, 8'h01, "R6 B after carry");
      step(3'd2, 2'd3, 16'h0, 1'b0, 3'd0, 8'h0, "R6 inc SP wrap");
      step(3'd3, 2'd1, 16'h0, 1'b0, 3'd0, 8'h0, "R6 dec DE");
      step(3'd1, 2'd0, 16'h0000, 1'b0, 3'd0, 8'h0, "R5 load BC zero");
      step(3'd3, 2'd0, 16'h0, 1'b0, 3'd0, 8'h0, "R6 dec BC wrap");
      // R7: double add
      step(3'd4, 2'd0, 16'h0, 1'b0, 3'd0, 8'h0, "R7 dad BC carry");
      step(3'd2, 2'd0, 16'h0, 1'b0, 3'd0, 8'h0, "R12 inc keeps carry");
      step(3'd4, 2'd2, 16'h0, 1'b0, 3'd0, 8'h0, "R7 dad HL self");
      step(3'd4, 2'd1, 16'h0, 1'b0, 3'd0, 8'h0, "R7 dad DE");
      step(3'd1, 2'd3, 16'h1234, 1'b0, 3'd0, 8'h0, "R5 load SP");
      step(3'd4, 2'd3, 16'h0, 1'b0, 3'd0, 8'h0, "R7 dad SP");
      // R8 / R9
      step(3'd5, 2'd0, 16'h0, 1'b0, 3'd0, 8'h0, "R8 swap");
      pchk(2'd1, "R8 DE after swap");
      step(3'd6, 2'd0, 16'h0, 1'b0, 3'd0, 8'h0, "R9 hl to sp");
      // R11: byte write dropped during pair ops
      step(3'd2, 2'd0, 16'h0, 1'b1, 3'd7, 8'hEE, "R11 inc drops A write");
      step(3'd5, 2'd1, 16'h0, 1'b1, 3'd4, 8'h11, "R11 swap drops H write");
      step(3'd1, 2'd2, 16'hA5C3, 1'b1, 3'd5, 8'h22, "R11 load drops L write");
      // R10: hl_addr follows single byte writes
      step(3'd0, 2'd2, 16'h0, 1'b1, 3'd4, 8'h3C, "R10 write H");
      step(3'd0, 2'd2, 16'h0, 1'b1, 3'd5, 8'hD2, "R10 write L");
      repeat (2) @(negedge clk);
      chk("R2 scoreboard drained", {31'd0, (sbq.size() == 0)}, 32'd1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
      $finish;
   end
endmodule